// File: doc/BRIEF.md
# Track and Reset Pulse Controller with Acquisition Sequencer

This block decodes one active-low control input that carries two meanings, telling them apart only by how long each low interval lasts in system clock cycles. A very short dip is discarded as noise. A dip within a middle window produces a single-cycle global reset strobe, issued once the input has returned high. A low level that outlasts the window is taken as a track hold: the hold flag rises as soon as the low count passes the upper limit and stays up until the input returns high.

The same block runs the per-channel acquisition sequence. When a channel is requested, the output buffer of that channel is switched to the analog input path at once. If the track hold is active, the sequence waits for the hold to end. Otherwise it starts straight away and drives an active-low busy signal. The acquisition ends when the converter reports completion or when a fixed cycle budget runs out, whichever comes first. The buffer is then returned to the DAC path and a one-cycle completion strobe tells the register bank which channel to capture. The channel selection is kept until the next request. A one-hot vector shows which channel is being acquired.

Top module: `trk_rst_ctrl`

## Requirements
- R1: After `rst_n` is released, `busy_n` is 1, `src_dac` is 1, `track_hold`, `sys_rst` and `acq_done` are 0, `acq_sel` is 0 and `ch_active` is all zeros.
- R2: A low interval on `trk_n` shorter than `MIN_CYC` cycles produces no reset strobe, and it does not disturb an acquisition that is in progress.
- R3: A low interval of `MIN_CYC` to `MAX_CYC` cycles (both limits included) produces `sys_rst` high for exactly one cycle, starting one cycle after the first high sample of `trk_n`.
- R4: `track_hold` rises one cycle after the `(MAX_CYC+1)`-th consecutive low sample and falls one cycle after the first high sample. A low interval this long never produces `sys_rst`.
- R5: A request (`acq_req` = 1 with `acq_ch`) that arrives while idle and while `track_hold` is 0 gives, on the next cycle, `busy_n` = 0, `src_dac` = 0 (input path) and `acq_sel` = `acq_ch`.
- R6: A request that arrives while `track_hold` is 1 sets `src_dac` = 0 and latches `acq_sel` on the next cycle, but keeps `busy_n` = 1. `busy_n` goes to 0 one cycle after `track_hold` falls.
- R7: `conv_done` = 1 during acquisition gives, on the next cycle, `busy_n` = 1, `src_dac` = 1 and `acq_done` high for exactly one cycle.
- R8: If `conv_done` never arrives, `busy_n` stays low for exactly `ACQ_CYC` cycles, and the sequence then completes as in R7.
- R9: A request that arrives while an acquisition is pending or running is ignored, and `acq_sel` keeps its value.
- R10: A `sys_rst` strobe returns the sequencer to the R1 state on the next cycle. It aborts any acquisition without an `acq_done` strobe and drops any request or `conv_done` that falls in the same cycle.
- R11: After completion, `acq_sel` keeps the last acquired channel until a new request is accepted.
- R12: `ch_active` has bit `acq_sel` set while a request is pending or acquiring, and is all zeros when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trk_n | input | 1 | Combined track/reset control, active low, synchronous to clk |
| acq_req | input | 1 | One-cycle acquisition request |
| acq_ch | input | CH_W | Channel for the request |
| conv_done | input | 1 | Converter reports acquisition finished |
| sys_rst | output | 1 | One-cycle global reset strobe |
| track_hold | output | 1 | Track hold in force |
| busy_n | output | 1 | Active-low acquisition busy |
| src_dac | output | 1 | Output buffer source: 1 DAC path, 0 input path |
| acq_sel | output | CH_W | Selected channel |
| ch_active | output | NUM_CH | One-hot channel under acquisition |
| acq_done | output | 1 | One-cycle completion strobe for the register bank |

## Verification
The width classifier and the acquisition sequencer can act in the same cycle. A reset strobe can fall in the cycle in which the converter reports completion and a fresh request is presented. The bench starts an acquisition and sends a mid-window pulse. In the cycle when the strobe is visible it raises both `conv_done` and `acq_req`. It then checks that no completion strobe is produced, that busy and source selection are back to their reset values, and that the dropped request does not start a new acquisition on the following cycle. Strobes are checked in order against expected events that a scoreboard queue holds.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HOLD = 2'd1,
        SQ_ACQ  = 2'd2
    } sq_state_e;

endpackage

// File: rtl/trk_width_cls.sv
module trk_width_cls #(
    parameter int MIN_CYC = 18,
    parameter int MAX_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trk_n_i,
    output logic rst_strobe_o,
    output logic track_o
);
    localparam int CNT_W = $clog2(MAX_CYC + 2);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             track;
        logic             strobe;
    } cls_t;

    localparam cls_t CLS_RST = '{cnt: '0, track: 1'b0, strobe: 1'b0};

    cls_t cls_q, cls_d;

    always_comb begin
        cls_d        = cls_q;
        cls_d.strobe = 1'b0;
        if (!trk_n_i) begin
            if (cls_q.cnt != SAT_V) begin
                cls_d.cnt = cls_q.cnt + 1'b1;
            end
            // count after this sample exceeds the upper limit
            cls_d.track = (cls_q.cnt >= MAX_V);
        end else begin
            if (cls_q.cnt != '0) begin
                cls_d.strobe = (cls_q.cnt >= MIN_V) && (cls_q.cnt <= MAX_V);
            end
            cls_d.cnt   = '0;
            cls_d.track = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cls_q <= CLS_RST;
        else        cls_q <= cls_d;
    end

    assign rst_strobe_o = cls_q.strobe;
    assign track_o      = cls_q.track;

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        cls_q.strobe |=> !cls_q.strobe);

    a_r3_strobe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        cls_q.strobe |-> ($past(trk_n_i) && !$past(trk_n_i, 2)));

    a_r4_track_from_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cls_q.track) |-> !$past(trk_n_i));

    a_r4_track_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cls_q.track |=> !cls_q.strobe);

endmodule

// File: rtl/acq_seq.sv
module acq_seq
    import trc_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int ACQ_CYC = 3200,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sys_rst_i,
    input  logic            track_i,
    input  logic            req_i,
    input  logic [CH_W-1:0] ch_i,
    input  logic            conv_done_i,
    output logic            busy_n_o,
    output logic            src_dac_o,
    output logic [CH_W-1:0] sel_o,
    output logic            active_o,
    output logic            done_o
);
    localparam int TM_W = $clog2(ACQ_CYC + 1);
    localparam logic [TM_W-1:0] TM_LAST = TM_W'(ACQ_CYC - 1);

    typedef struct packed {
        sq_state_e       state;
        logic [CH_W-1:0] sel;
        logic [TM_W-1:0] timer;
        logic            busy_n;
        logic            src_dac;
        logic            done;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: SQ_IDLE, sel: '0, timer: '0,
                                 busy_n: 1'b1, src_dac: 1'b1, done: 1'b0};

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (sys_rst_i) begin
            seq_d = SEQ_RST;
        end else begin
            unique case (seq_q.state)
                SQ_IDLE: begin
                    if (req_i) begin
                        seq_d.sel     = ch_i;
                        seq_d.src_dac = 1'b0;
                        seq_d.timer   = '0;
                        if (track_i) begin
                            seq_d.state = SQ_HOLD;
                        end else begin
                            seq_d.state  = SQ_ACQ;
                            seq_d.busy_n = 1'b0;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (!track_i) begin
                        seq_d.state  = SQ_ACQ;
                        seq_d.busy_n = 1'b0;
                        seq_d.timer  = '0;
                    end
                end
                SQ_ACQ: begin
                    if (conv_done_i || (seq_q.timer == TM_LAST)) begin
                        seq_d.state   = SQ_IDLE;
                        seq_d.busy_n  = 1'b1;
                        seq_d.src_dac = 1'b1;
                        seq_d.done    = 1'b1;
                    end else begin
                        seq_d.timer = seq_q.timer + 1'b1;
                    end
                end
                default: seq_d = SEQ_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign busy_n_o  = seq_q.busy_n;
    assign src_dac_o = seq_q.src_dac;
    assign sel_o     = seq_q.sel;
    assign active_o  = (seq_q.state != SQ_IDLE);
    assign done_o    = seq_q.done;

    a_r5_busy_on_input: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.busy_n |-> !seq_q.src_dac);

    a_r6_hold_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == SQ_HOLD) |-> seq_q.busy_n);

    a_r7_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> (seq_q.busy_n && seq_q.src_dac && !$past(seq_q.busy_n)));

    a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.timer <= TM_LAST);

    a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state != SQ_IDLE && !sys_rst_i) |=> $stable(seq_q.sel));

    a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_i |=> (seq_q.busy_n && seq_q.src_dac && !seq_q.done));

endmodule

// File: rtl/ch_onehot.sv
module ch_onehot #(
    parameter int NUM_CH = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              en_i,
    input  logic [CH_W-1:0]   sel_i,
    output logic [NUM_CH-1:0] vec_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
        assign vec_o[g] = en_i && (sel_i == CH_W'(g));
    end
endmodule

// File: rtl/trk_rst_ctrl.sv
module trk_rst_ctrl #(
    parameter int NUM_CH  = 32,
    parameter int MIN_CYC = 18,
    parameter int MAX_CYC = 40,
    parameter int ACQ_CYC = 3200,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trk_n,
    input  logic              acq_req,
    input  logic [CH_W-1:0]   acq_ch,
    input  logic              conv_done,
    output logic              sys_rst,
    output logic              track_hold,
    output logic              busy_n,
    output logic              src_dac,
    output logic [CH_W-1:0]   acq_sel,
    output logic [NUM_CH-1:0] ch_active,
    output logic              acq_done
);
    logic seq_active;

    trk_width_cls #(
        .MIN_CYC (MIN_CYC),
        .MAX_CYC (MAX_CYC)
    ) u_cls (
        .clk          (clk),
        .rst_n        (rst_n),
        .trk_n_i      (trk_n),
        .rst_strobe_o (sys_rst),
        .track_o      (track_hold)
    );

    acq_seq #(
        .NUM_CH  (NUM_CH),
        .ACQ_CYC (ACQ_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sys_rst_i   (sys_rst),
        .track_i     (track_hold),
        .req_i       (acq_req),
        .ch_i        (acq_ch),
        .conv_done_i (conv_done),
        .busy_n_o    (busy_n),
        .src_dac_o   (src_dac),
        .sel_o       (acq_sel),
        .active_o    (seq_active),
        .done_o      (acq_done)
    );

    ch_onehot #(
        .NUM_CH (NUM_CH)
    ) u_dec (
        .en_i  (seq_active),
        .sel_i (acq_sel),
        .vec_o (ch_active)
    );

    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_active));

    a_r12_busy_has_channel: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> ch_active[acq_sel]);

    a_r10_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_rst && acq_done));

endmodule

// File: tb/tb_trk_rst_ctrl.sv
module tb_trk_rst_ctrl;
    localparam int NUM_CH  = 32;
    localparam int MIN_CYC = 18;
    localparam int MAX_CYC = 40;
    localparam int ACQ_CYC = 3200;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int EV_RST  = 0;
    localparam int EV_DONE = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trk_n = 1'b1;
    logic              acq_req = 1'b0;
    logic [CH_W-1:0]   acq_ch = '0;
    logic              conv_done = 1'b0;
    logic              sys_rst, track_hold, busy_n, src_dac, acq_done;
    logic [CH_W-1:0]   acq_sel;
    logic [NUM_CH-1:0] ch_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int kind;
        int ch;
    } ev_t;
    ev_t exp_q[$];

    always #2.5 clk = ~clk;

    trk_rst_ctrl #(
        .NUM_CH (NUM_CH), .MIN_CYC (MIN_CYC), .MAX_CYC (MAX_CYC), .ACQ_CYC (ACQ_CYC)
    ) dut (
        .clk (clk), .rst_n (rst_n), .trk_n (trk_n), .acq_req (acq_req),
        .acq_ch (acq_ch), .conv_done (conv_done), .sys_rst (sys_rst),
        .track_hold (track_hold), .busy_n (busy_n), .src_dac (src_dac),
        .acq_sel (acq_sel), .ch_active (ch_active), .acq_done (acq_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_low(input int w);
        trk_n = 1'b0;
        repeat (w) tick();
        trk_n = 1'b1;
    endtask

    task automatic expect_ev(input int kind, input int ch);
        ev_t e;
        e.kind = kind;
        e.ch   = ch;
        exp_q.push_back(e);
    endtask

    task automatic request(input int ch);
        acq_req = 1'b1;
        acq_ch  = CH_W'(ch);
        tick();
        acq_req = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished && (sys_rst || acq_done)) begin
            ev_t e;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                if (sys_rst) $display("FAIL R2: unexpected reset strobe, actual 1 expected 0");
                else         $display("FAIL R10: unexpected done strobe ch %0d, actual 1 expected 0", acq_sel);
            end else begin
                e = exp_q.pop_front();
                if (sys_rst && e.kind != EV_RST) begin
                    n_fail++;
                    $display("FAIL R3: event kind actual %0d expected %0d", EV_RST, e.kind);
                end else if (acq_done && (e.kind != EV_DONE || int'(acq_sel) != e.ch)) begin
                    n_fail++;
                    $display("FAIL R7: done on ch actual %0d expected kind %0d ch %0d",
                             acq_sel, e.kind, e.ch);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int nb;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        chk("R1 busy_n", busy_n, 1);
        chk("R1 src_dac", src_dac, 1);
        chk("R1 track_hold", track_hold, 0);
        chk("R1 sys_rst", sys_rst, 0);
        chk("R1 acq_done", acq_done, 0);
        chk("R1 acq_sel", acq_sel, 0);
        chk("R1 ch_active", ch_active, 0);

        // R2: glitch just under the lower limit
        pulse_low(MIN_CYC - 1);
        tick();
        @(negedge clk);
        chk("R2 glitch no strobe", sys_rst, 0);
        chk("R2 glitch no track", track_hold, 0);

        // R3: both window limits
        expect_ev(EV_RST, 0);
        pulse_low(MIN_CYC);
        tick();
        @(negedge clk);
        chk("R3 strobe at lower limit", sys_rst, 1);
        tick();
        @(negedge clk);
        chk("R3 strobe one cycle", sys_rst, 0);
        expect_ev(EV_RST, 0);
        pulse_low(MAX_CYC);
        tick();
        @(negedge clk);
        chk("R3 strobe at upper limit", sys_rst, 1);
        tick();

        // R4: track hold timing
        trk_n = 1'b0;
        repeat (MAX_CYC) tick();
        @(negedge clk);
        chk("R4 no track at upper limit", track_hold, 0);
        tick();
        @(negedge clk);
        chk("R4 track after limit", track_hold, 1);
        repeat (4) tick();
        trk_n = 1'b1;
        tick();
        @(negedge clk);
        chk("R4 track released", track_hold, 0);
        chk("R4 no strobe after long low", sys_rst, 0);

        // R5, R12: immediate acquisition
        request(5);
        @(negedge clk);
        chk("R5 busy low", busy_n, 0);
        chk("R5 input path", src_dac, 0);
        chk("R5 channel", acq_sel, 5);
        chk("R12 one-hot active", ch_active, 32'h1 << 5);

        // R9: request while busy ignored
        request(9);
        @(negedge clk);
        chk("R9 sel kept", acq_sel, 5);

        // R2: glitch during acquisition leaves it running
        pulse_low(MIN_CYC - 1);
        tick();
        @(negedge clk);
        chk("R2 acquisition unaffected", busy_n, 0);

        // R7: completion by converter
        expect_ev(EV_DONE, 5);
        conv_done = 1'b1;
        tick();
        conv_done = 1'b0;
        @(negedge clk);
        chk("R7 busy released", busy_n, 1);
        chk("R7 dac path", src_dac, 1);
        chk("R7 done strobe", acq_done, 1);
        chk("R12 idle vector", ch_active, 0);
        repeat (3) tick();
        @(negedge clk);
        chk("R7 done single", acq_done, 0);
        chk("R11 sel held", acq_sel, 5);

        // R8: completion by timeout
        expect_ev(EV_DONE, 7);
        request(7);
        nb = 0;
        do begin
            @(negedge clk);
            if (!busy_n) nb++;
        end while (!busy_n && nb < 10000);
        chk("R8 busy cycles", nb, ACQ_CYC);
        chk("R8 done strobe", acq_done, 1);

        // R6: request during track hold
        trk_n = 1'b0;
        repeat (MAX_CYC + 1) tick();
        expect_ev(EV_DONE, 12);
        request(12);
        @(negedge clk);
        chk("R6 not busy in hold", busy_n, 1);
        chk("R6 input path", src_dac, 0);
        chk("R6 channel", acq_sel, 12);
        chk("R12 active in hold", ch_active, 32'h1 << 12);
        repeat (5) tick();
        @(negedge clk);
        chk("R6 still waiting", busy_n, 1);
        trk_n = 1'b1;
        tick();
        @(negedge clk);
        chk("R6 track fell", track_hold, 0);
        chk("R6 busy not yet", busy_n, 1);
        tick();
        @(negedge clk);
        chk("R6 busy after track", busy_n, 0);
        conv_done = 1'b1;
        tick();
        conv_done = 1'b0;
        @(negedge clk);
        chk("R6 done after hold", acq_done, 1);

        // R10: reset strobe coincides with done and new request
        request(3);
        expect_ev(EV_RST, 0);
        pulse_low(30);
        tick();
        conv_done = 1'b1;
        acq_req   = 1'b1;
        acq_ch    = CH_W'(20);
        tick();
        conv_done = 1'b0;
        acq_req   = 1'b0;
        @(negedge clk);
        chk("R10 busy cleared", busy_n, 1);
        chk("R10 dac path", src_dac, 1);
        chk("R10 sel cleared", acq_sel, 0);
        chk("R10 no done", acq_done, 0);
        tick();
        @(negedge clk);
        chk("R10 request dropped", busy_n, 1);
        chk("R10 nothing active", ch_active, 0);

        repeat (3) tick();
        chk("R7 scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule